// File: doc/BRIEF.md
# Serial Flash Write-Permission Front End

This block sits behind the serial pins of a flash device and handles only the instructions that grant or withdraw write permission. While chip select is low it shifts opcode bits in on the rising edges of the serial clock, most significant bit first. It accepts both idle clock levels: low (mode 0) and high (mode 3). Nothing happens while the bits arrive. The captured opcode is acted on only in the cycle where chip select is seen to rise, and only if exactly eight bits were clocked in.

The block keeps three pieces of state: a write-enable latch, an auto-increment flag and a one-shot arm for a status-register write. The serial pins and chip select are brought into a fast system clock domain through synchronizers. The program/erase sequencer asks for permission through `wr_req`, and a grant comes back on `wr_accept` only while the latch is set. The same sequencer can request auto-increment mode. When the arming opcode is followed directly by the status-register write opcode, the block emits a single-cycle grant to the status register. Any other frame in between throws the arm away.

Top module: `wrperm_ctrl`

## Requirements
- R1: A complete 8-bit frame carrying opcode 0x06 sets `wel` to 1 once chip select rises.
- R2: A complete frame carrying opcode 0x04 clears both `wel` and `aai` to 0 once chip select rises.
- R3: Opcode bits are taken on rising serial-clock edges, most significant bit first. State does not change while a frame is still open, even after eight bits.
- R4: A frame that ends after any bit count other than 8, or that carries an opcode not named in R1, R2 or R5, leaves `wel` and `aai` unchanged and clears the status-write arm.
- R5: Opcode 0x50 arms a status-register write. If the very next complete frame is opcode 0x01, `sr_wr_grant` pulses high for exactly one clock.
- R6: Opcode 0x01 produces no grant unless the frame directly before it was 0x50. Any intervening frame, such as 0x01 or 0x06, discards the arm.
- R7: `wr_accept` pulses one clock after `wr_req` is high, and only if `wel` was 1 in the cycle of the request.
- R8: `aai_req` sets `aai` to 1 only while `wel` is 1. Otherwise it is ignored.
- R9: If a command executes in the same clock as `aai_req` or `wr_req`, both requests see the latch value from before the command. A clearing command takes priority over an auto-increment set arriving in the same clock.
- R10: The serial output enable `spi_miso_oe` stays 0 at all times.
- R11: Asserting `rst_n` low clears `wel`, `aai` and the status-write arm.
- R12: Frames sent with the serial clock idling high (mode 3) are decoded exactly like frames sent with it idling low (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host (unused by these instructions) |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`, held low |
| wr_req | input | 1 | Program/erase permission request from the sequencer |
| aai_req | input | 1 | Request to enter auto-address-increment mode |
| wel | output | 1 | Write-enable latch state |
| aai | output | 1 | Auto-address-increment flag state |
| wr_accept | output | 1 | One-cycle grant for a program/erase request |
| sr_wr_grant | output | 1 | One-cycle grant for a status-register write |

## Verification
The execution of a just-closed frame and a sequencer request (`aai_req` or `wr_req`) can fall in the same system-clock cycle. The bench counts the synchronizer stages from the chip-select rise and drives the request on exactly the clock edge where the command executes. It judges the result by the latch-before-update rule: a 0x06 executed with a concurrent `wr_req` yields no `wr_accept`, while a 0x04 executed alongside both requests still yields a `wr_accept` and leaves `aai` at 0.

// File: rtl/wrperm_pkg.sv
package wrperm_pkg;

  localparam int OP_W = 8;

  typedef logic [OP_W-1:0] opcode_t;

  // Opcode values the block reacts to
  localparam opcode_t OPC_SET_WEL = 8'h06;
  localparam opcode_t OPC_CLR_WEL = 8'h04;
  localparam opcode_t OPC_SR_ARM  = 8'h50;
  localparam opcode_t OPC_SR_WR   = 8'h01;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,  // incomplete frame
    CMD_SET_WEL = 3'd1,
    CMD_CLR_WEL = 3'd2,
    CMD_SR_ARM  = 3'd3,
    CMD_SR_WR   = 3'd4,
    CMD_OTHER   = 3'd5   // complete frame, unrecognized opcode
  } cmd_e;

endpackage

// File: rtl/wrperm_sync.sv
module wrperm_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/wrperm_shift.sv
module wrperm_shift
  import wrperm_pkg::*;
#(
  parameter int W = OP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_s,
  input  logic         cs_n_s,
  input  logic         mosi_s,
  output logic [W-1:0] opcode,
  output logic         frame_ok,
  output logic         exec
);

  localparam int             CNT_W   = $clog2(W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

  logic             sck_prev_q, cs_prev_q;
  logic             sck_rise, cs_rise, cs_act;
  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sh_en;

  assign sck_rise = sck_s & ~sck_prev_q;
  assign cs_rise  = cs_n_s & ~cs_prev_q;
  assign cs_act   = ~cs_n_s;
  assign sh_en    = cs_act & sck_rise;

  always_comb begin
    sh_d  = {sh_q[W-2:0], mosi_s};
    cnt_d = cnt_q;
    if (!cs_act) begin
      cnt_d = '0;
    end else if (sck_rise && (cnt_q != CNT_SAT)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      cs_prev_q  <= cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign opcode   = sh_q;
  assign frame_ok = (cnt_q == CNT_FULL);
  assign exec     = cs_rise;

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt_q == '0)); // R4

  AST_SHIFT_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/wrperm_decode.sv
module wrperm_decode
  import wrperm_pkg::*;
(
  input  opcode_t opcode,
  input  logic    frame_ok,
  output cmd_e    cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (frame_ok) begin
      unique case (opcode)
        OPC_SET_WEL: cmd = CMD_SET_WEL;
        OPC_CLR_WEL: cmd = CMD_CLR_WEL;
        OPC_SR_ARM:  cmd = CMD_SR_ARM;
        OPC_SR_WR:   cmd = CMD_SR_WR;
        default:     cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/wrperm_state.sv
module wrperm_state
  import wrperm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exec,
  input  cmd_e cmd,
  input  logic wr_req,
  input  logic aai_req,
  output logic wel,
  output logic aai,
  output logic wr_accept,
  output logic sr_wr_grant
);

  logic wel_q, wel_d;
  logic aai_q, aai_d;
  logic arm_q, arm_d;
  logic acc_q, acc_d;
  logic grant_q, grant_d;
  logic state_en;

  // Requests look at the latch value held before this cycle's command
  always_comb begin
    wel_d   = wel_q;
    aai_d   = aai_q;
    arm_d   = arm_q;
    grant_d = 1'b0;
    acc_d   = wr_req & wel_q;
    if (aai_req && wel_q) aai_d = 1'b1;
    if (exec) begin
      arm_d = 1'b0;
      unique case (cmd)
        CMD_SET_WEL: wel_d = 1'b1;
        CMD_CLR_WEL: begin
          wel_d = 1'b0;
          aai_d = 1'b0;
        end
        CMD_SR_ARM:  arm_d   = 1'b1;
        CMD_SR_WR:   grant_d = arm_q;
        default:     ;
      endcase
    end
  end

  assign state_en = exec | (aai_req & wel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      aai_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (state_en) begin
      wel_q <= wel_d;
      aai_q <= aai_d;
      arm_q <= arm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      grant_q <= grant_d;
    end
  end

  assign wel         = wel_q;
  assign aai         = aai_q;
  assign wr_accept   = acc_q;
  assign sr_wr_grant = grant_q;

  AST_SET_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == CMD_SET_WEL) |=> wel_q); // R1

  AST_CLR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == CMD_CLR_WEL) |=> (!wel_q && !aai_q)); // R2

  AST_WEL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(wel_q)); // R3

  AST_BAD_FRAME_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (cmd == CMD_NONE || cmd == CMD_OTHER)) |=> ($stable(wel_q) && !arm_q)); // R4

  AST_GRANT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_grant |-> $past(arm_q)); // R5

  AST_ARM_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd != CMD_SR_ARM) |=> !arm_q); // R6

  AST_ACCEPT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> ($past(wr_req) && $past(wel_q))); // R7

  AST_AAI_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aai_q) |-> $past(wel_q)); // R8

endmodule

// File: rtl/wrperm_ctrl.sv
module wrperm_ctrl
  import wrperm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe,
  input  logic wr_req,
  input  logic aai_req,
  output logic wel,
  output logic aai,
  output logic wr_accept,
  output logic sr_wr_grant
);

  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_RST = 3'b010; // cs_n idles high

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [PIN_W-1:0] pins_s;
  opcode_t          opcode;
  logic             frame_ok;
  logic             exec;
  cmd_e             cmd;

  // Reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wrperm_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   ({spi_mosi, spi_cs_n, spi_sck}),
    .dout  (pins_s)
  );

  wrperm_shift #(
    .W (OP_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sck_s    (pins_s[0]),
    .cs_n_s   (pins_s[1]),
    .mosi_s   (pins_s[2]),
    .opcode   (opcode),
    .frame_ok (frame_ok),
    .exec     (exec)
  );

  wrperm_decode u_decode (
    .opcode   (opcode),
    .frame_ok (frame_ok),
    .cmd      (cmd)
  );

  wrperm_state u_state (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .exec        (exec),
    .cmd         (cmd),
    .wr_req      (wr_req),
    .aai_req     (aai_req),
    .wel         (wel),
    .aai         (aai),
    .wr_accept   (wr_accept),
    .sr_wr_grant (sr_wr_grant)
  );

  // These instructions never drive the serial output
  assign spi_miso    = 1'b0;
  assign spi_miso_oe = 1'b0;

endmodule

// File: tb/wrperm_ctrl_tb.sv
module wrperm_ctrl_tb;

  localparam int HALF = 4;     // system clocks per serial half period
  localparam int SETTLE = 10;  // clocks from chip-select rise to sampling
  localparam int NVEC = 16;

  // {mode3, nbits[3:0], opcode[7:0], pulse_aai, exp_wel, exp_aai, exp_grant}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 4'd8, 8'h06, 1'b0, 1'b1, 1'b0, 1'b0},  // R1
    {1'b1, 4'd8, 8'h50, 1'b1, 1'b1, 1'b1, 1'b0},  // R12 R8
    {1'b0, 4'd8, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1},  // R5
    {1'b0, 4'd8, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0},  // R6
    {1'b1, 4'd8, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0},  // R2
    {1'b0, 4'd8, 8'h50, 1'b1, 1'b0, 1'b0, 1'b0},  // R8
    {1'b0, 4'd8, 8'h06, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
    {1'b0, 4'd8, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
    {1'b1, 4'd8, 8'h50, 1'b0, 1'b1, 1'b0, 1'b0},  // R5
    {1'b0, 4'd7, 8'h04, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
    {1'b0, 4'd8, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
    {1'b1, 4'd9, 8'h04, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
    {1'b0, 4'd8, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
    {1'b0, 4'd8, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0},  // R3
    {1'b0, 4'd8, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0},  // R2
    {1'b1, 4'd8, 8'h60, 1'b0, 1'b0, 1'b0, 1'b0}   // R3
  };
  localparam string VTAG [NVEC] = '{
    "R1", "R12", "R5", "R6", "R2", "R8", "R6", "R6",
    "R5", "R4", "R4", "R4", "R4", "R3", "R2", "R3"
  };

  logic clk;
  logic rst_n;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso, spi_miso_oe;
  logic wr_req, aai_req;
  logic wel, aai, wr_accept, sr_wr_grant;

  int checks;
  int fails;
  int grant_cnt;
  int acc_cnt;
  int oe_bad;
  bit done;

  wrperm_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sck     (spi_sck),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .wr_req      (wr_req),
    .aai_req     (aai_req),
    .wel         (wel),
    .aai         (aai),
    .wr_accept   (wr_accept),
    .sr_wr_grant (sr_wr_grant)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    if (sr_wr_grant === 1'b1) grant_cnt++;
    if (wr_accept === 1'b1)   acc_cnt++;
    if (spi_miso_oe !== 1'b0) oe_bad++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_bits(input bit mode3, input int nbits, input logic [7:0] op);
    @(negedge clk);
    spi_sck  = mode3;
    wait_clks(HALF);
    spi_cs_n = 1'b0;
    wait_clks(HALF);
    for (int k = 0; k < nbits; k++) begin
      if (mode3) spi_sck = 1'b0;
      spi_mosi = (k < 8) ? op[7-k] : 1'b0;
      wait_clks(HALF);
      spi_sck = 1'b1;
      wait_clks(HALF);
      if (!mode3) spi_sck = 1'b0;
    end
    wait_clks(HALF);
  endtask

  // Raises chip select; optional requests land on the execute edge
  task automatic frame_end(input bit al_wr, input bit al_aai);
    spi_cs_n = 1'b1;
    wait_clks(2);
    wr_req  = al_wr;
    aai_req = al_aai;
    wait_clks(1);
    wr_req  = 1'b0;
    aai_req = 1'b0;
    wait_clks(SETTLE);
  endtask

  task automatic pulse_aai();
    aai_req = 1'b1;
    wait_clks(1);
    aai_req = 1'b0;
    wait_clks(2);
  endtask

  task automatic pulse_wr();
    wr_req = 1'b1;
    wait_clks(1);
    wr_req = 1'b0;
    wait_clks(3);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int g0;
    int a0;
    checks = 0; fails = 0; grant_cnt = 0; acc_cnt = 0; oe_bad = 0; done = 1'b0;
    spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    wr_req = 1'b0; aai_req = 1'b0;
    rst_n = 1'b0;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(6);

    // R11: reset state
    check("R11 wel after reset", int'(wel), 0);
    check("R11 aai after reset", int'(aai), 0);
    check("R7 no accept while latch clear", int'(wr_accept), 0);

    // R7: request refused with latch clear
    a0 = acc_cnt;
    pulse_wr();
    check("R7 refused without wel", acc_cnt - a0, 0);

    // R3: eight bits shifted but chip select still low -> no change
    frame_bits(1'b0, 8, 8'h06);
    wait_clks(SETTLE);
    check("R3 no change before cs rise", int'(wel), 0);
    frame_end(1'b0, 1'b0);
    check("R3 executes at cs rise", int'(wel), 1);

    // R7: accepted with latch set
    a0 = acc_cnt;
    pulse_wr();
    check("R7 accepted with wel", acc_cnt - a0, 1);

    // clear back to a known state for the table
    frame_bits(1'b0, 8, 8'h04);
    frame_end(1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] v;
      v = VEC[i];
      g0 = grant_cnt;
      if (v[3]) pulse_aai();
      frame_bits(v[16], int'(v[15:12]), v[11:4]);
      frame_end(1'b0, 1'b0);
      check($sformatf("%s vec%0d wel", VTAG[i], i), int'(wel), int'(v[2]));
      check($sformatf("%s vec%0d aai", VTAG[i], i), int'(aai), int'(v[1]));
      check($sformatf("%s vec%0d grant", VTAG[i], i), grant_cnt - g0, int'(v[0]));
    end

    // R9: wr_req on the edge where 0x06 executes sees the old latch (0)
    a0 = acc_cnt;
    frame_bits(1'b0, 8, 8'h06);
    frame_end(1'b1, 1'b0);
    check("R9 accept uses pre-update wel", acc_cnt - a0, 0);
    check("R9 wel set after same-cycle", int'(wel), 1);

    // R9: 0x04 executes with wr_req and aai_req on the same edge
    pulse_aai();
    check("R8 aai set with wel", int'(aai), 1);
    a0 = acc_cnt;
    frame_bits(1'b1, 8, 8'h04);
    frame_end(1'b1, 1'b1);
    check("R9 accept with old wel", acc_cnt - a0, 1);
    check("R9 clear wins over aai set", int'(aai), 0);
    check("R9 wel cleared", int'(wel), 0);

    // R5 in mode 3 with both frames back to back
    g0 = grant_cnt;
    frame_bits(1'b1, 8, 8'h50);
    frame_end(1'b0, 1'b0);
    frame_bits(1'b1, 8, 8'h01);
    frame_end(1'b0, 1'b0);
    check("R5 R12 grant in mode 3", grant_cnt - g0, 1);

    // R11: reset clears latch, flag and arm
    frame_bits(1'b0, 8, 8'h06);
    frame_end(1'b0, 1'b0);
    pulse_aai();
    frame_bits(1'b0, 8, 8'h50);
    frame_end(1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    wait_clks(3);
    check("R11 wel cleared by reset", int'(wel), 0);
    check("R11 aai cleared by reset", int'(aai), 0);
    rst_n = 1'b1;
    wait_clks(6);
    g0 = grant_cnt;
    frame_bits(1'b0, 8, 8'h01);
    frame_end(1'b0, 1'b0);
    check("R11 arm cleared by reset", grant_cnt - g0, 0);

    // R10: output enable never raised
    check("R10 miso_oe stayed low", oe_bad, 0);

    finish_run();
  end

endmodule